// File: doc/BRIEF.md
# Display Controller Bring-Up and Clear Sequencer

This block brings up an external display controller after reset. On a start pulse it first sends a fixed series of controller commands, each followed by its parameter bytes. Some commands are followed by timed pauses for the controller's clock and reset. It then opens a write window that covers the full frame. Into that window it streams one 16-bit RGB565 colour for every pixel. Last, it sends the display-enable command, waits once more and pulses `done`.

Every item leaves on a single tagged stream with a valid/ready handshake, and a bus writer consumes it. The tag tells the writer whether an item is a command byte, a parameter byte or a pixel word. The writer can therefore drive the controller's data/command select line from the tag. The sequencer moves forward only when the writer accepts the item on offer.

The frame size is set by `WIDTH` and `HEIGHT`, which default to 480×272, or 130560 pixels. Pause lengths are counted in clocks from `CLKS_PER_MS`.

States:
- `S_IDLE` waits for `start`. On `start` it moves to `S_CMD`.
- `S_CMD` offers an opcode. When the opcode is accepted, the next state is `S_PARAM` if the command has parameters. Otherwise the post-command step decides.
- `S_PARAM` offers parameter bytes. After the last byte is accepted, the post-command step decides.
- `S_PIXEL` offers the colour. After the final pixel it moves to `S_CMD` for the next command.
- `S_WAIT` counts down a pause. When the pause ends it moves to `S_CMD`, or to `S_IDLE` with `done` after the final command.

The post-command step chooses `S_PIXEL` for the fill command, `S_WAIT` for a command that has a pause, and `S_CMD` for all others.

Top module: `disp_bringup_seq`

## Requirements
- R1: After reset, `item_valid` and `done` are low, and nothing is offered until `start` is seen in idle.
- R2: Opcodes go out in this order, with these parameter counts: E2/3, E0/1, E0/1, 01/0, E6/3, B0/7, B4/8, B6/7, BA/1, B8/2, 36/1, BE/6, D0/1, F0/1, 2A/4, 2B/4, 2C/0, 29/0. The kind codes are 0 for a command, 1 for a parameter and 2 for a pixel. A command or parameter byte sits in `item_data[7:0]`, and `item_data[15:8]` is zero.
- R3: The parameter of the first E0 is 0x01. The parameter of the second E0 is 0x03. The parameter of F0 is 0x03, which selects 16-bit 565 pixels.
- R4: After the accepted E0 parameters there are pauses of 1 ms and 5 ms. After 01 there is a 5 ms pause, and after the parameter of 36 a 50 ms pause. Each pause is exactly n×`CLKS_PER_MS` cycles with `item_valid` low.
- R5: The 2A parameters are 00, 00, (WIDTH-1)>>8 and (WIDTH-1)&FF. The 2B parameters are built the same way from HEIGHT. Every 16-bit value is sent high byte first.
- R6: Between 2C and 29 there are exactly WIDTH×HEIGHT pixel items, each of kind 2, each carrying the fill colour.
- R7: An offered item holds its kind and data until it is accepted. Stalls on `item_ready` do not change the accepted sequence.
- R8: The fill colour is sampled at start. Later changes on `fill_colour` have no effect.
- R9: After 29 is accepted there is a 5 ms pause. Then `done` is high for exactly one cycle with `item_valid` low, and the block returns to idle.
- R10: A `start` that arrives while a sequence is running is ignored.
- R11: Outside the pauses of R4 and R9, the next item is offered in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sequence when idle |
| fill_colour | input | 16 | RGB565 colour for the clear, sampled at start |
| item_valid | output | 1 | An item is on offer |
| item_ready | input | 1 | The downstream writer accepts the item on offer |
| item_kind | output | 2 | 0 command, 1 parameter, 2 pixel |
| item_data | output | 16 | Byte in [7:0] for commands and parameters, the pixel word for pixels |
| done | output | 1 | One-cycle pulse after the final pause |

## Verification
Faults in the command or parameter index show up at once as a wrong opcode or parameter count in the tagged stream. A fault in the timer shows up as a pause with the wrong number of low-valid cycles, measured exactly against `CLKS_PER_MS`. A faulty pixel counter makes the pixel total between 2C and 29 wrong, and that is seen before display-on. A fault in the done logic shows up as a missing or repeated pulse, or as items offered after it, within the cycles that follow the final pause.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_PARAM = 2'd1,
        KIND_PIXEL = 2'd2
    } item_kind_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [3:0] n_params;
        logic [5:0] wait_ms;
        logic       fill;
        logic       last;
    } cmd_entry_t;

    localparam int N_CMDS   = 18;
    localparam int N_PARAMS = 50;
    localparam int MAX_MS   = 50;

endpackage

// File: rtl/dsq_cmd_rom.sv
module dsq_cmd_rom
    import dsq_pkg::*;
(
    input  logic [4:0] idx,
    output cmd_entry_t entry
);
    // fields: opcode, parameter count, pause after (ms), fill follows, final
    always_comb begin
        unique case (idx)
            5'd0:    entry = '{8'hE2, 4'd3, 6'd0,  1'b0, 1'b0};
            5'd1:    entry = '{8'hE0, 4'd1, 6'd1,  1'b0, 1'b0};
            5'd2:    entry = '{8'hE0, 4'd1, 6'd5,  1'b0, 1'b0};
            5'd3:    entry = '{8'h01, 4'd0, 6'd5,  1'b0, 1'b0};
            5'd4:    entry = '{8'hE6, 4'd3, 6'd0,  1'b0, 1'b0};
            5'd5:    entry = '{8'hB0, 4'd7, 6'd0,  1'b0, 1'b0};
            5'd6:    entry = '{8'hB4, 4'd8, 6'd0,  1'b0, 1'b0};
            5'd7:    entry = '{8'hB6, 4'd7, 6'd0,  1'b0, 1'b0};
            5'd8:    entry = '{8'hBA, 4'd1, 6'd0,  1'b0, 1'b0};
            5'd9:    entry = '{8'hB8, 4'd2, 6'd0,  1'b0, 1'b0};
            5'd10:   entry = '{8'h36, 4'd1, 6'd50, 1'b0, 1'b0};
            5'd11:   entry = '{8'hBE, 4'd6, 6'd0,  1'b0, 1'b0};
            5'd12:   entry = '{8'hD0, 4'd1, 6'd0,  1'b0, 1'b0};
            5'd13:   entry = '{8'hF0, 4'd1, 6'd0,  1'b0, 1'b0};
            5'd14:   entry = '{8'h2A, 4'd4, 6'd0,  1'b0, 1'b0};
            5'd15:   entry = '{8'h2B, 4'd4, 6'd0,  1'b0, 1'b0};
            5'd16:   entry = '{8'h2C, 4'd0, 6'd0,  1'b1, 1'b0};
            5'd17:   entry = '{8'h29, 4'd0, 6'd5,  1'b0, 1'b1};
            default: entry = '{8'h00, 4'd0, 6'd0,  1'b0, 1'b1};
        endcase
    end
endmodule

// File: rtl/dsq_param_rom.sv
module dsq_param_rom #(
    parameter int WIDTH  = 480,
    parameter int HEIGHT = 272
) (
    input  logic [5:0] idx,
    output logic [7:0] value
);
    localparam logic [15:0] COL_END = 16'(WIDTH - 1);
    localparam logic [15:0] ROW_END = 16'(HEIGHT - 1);

    // parameter bytes in the order the commands consume them, high byte first
    always_comb begin
        unique case (idx)
            6'd0:  value = 8'h23;  6'd1:  value = 8'h02;  6'd2:  value = 8'h04;
            6'd3:  value = 8'h01;
            6'd4:  value = 8'h03;
            6'd5:  value = 8'h01;  6'd6:  value = 8'h45;  6'd7:  value = 8'h47;
            6'd8:  value = 8'h20;  6'd9:  value = 8'h00;
            6'd10: value = COL_END[15:8]; 6'd11: value = COL_END[7:0];
            6'd12: value = ROW_END[15:8]; 6'd13: value = ROW_END[7:0];
            6'd14: value = 8'h00;
            6'd15: value = 8'h02;  6'd16: value = 8'h13;  6'd17: value = 8'h00;
            6'd18: value = 8'h2B;  6'd19: value = 8'h0A;  6'd20: value = 8'h00;
            6'd21: value = 8'h08;  6'd22: value = 8'h00;
            6'd23: value = 8'h01;  6'd24: value = 8'h20;  6'd25: value = 8'h00;
            6'd26: value = 8'h0C;  6'd27: value = 8'h0A;  6'd28: value = 8'h00;
            6'd29: value = 8'h01;
            6'd30: value = 8'h05;
            6'd31: value = 8'h07;  6'd32: value = 8'h01;
            6'd33: value = 8'h00;
            6'd34: value = 8'h06;  6'd35: value = 8'h80;  6'd36: value = 8'h01;
            6'd37: value = 8'hF0;  6'd38: value = 8'h00;  6'd39: value = 8'h00;
            6'd40: value = 8'h0D;
            6'd41: value = 8'h03;
            6'd42: value = 8'h00;  6'd43: value = 8'h00;
            6'd44: value = COL_END[15:8]; 6'd45: value = COL_END[7:0];
            6'd46: value = 8'h00;  6'd47: value = 8'h00;
            6'd48: value = ROW_END[15:8]; 6'd49: value = ROW_END[7:0];
            default: value = 8'h00;
        endcase
    end
endmodule

// File: rtl/dsq_delay_timer.sv
module dsq_delay_timer #(
    parameter int CLKS_PER_MS = 50000,
    parameter int MAX_MS      = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [5:0] ms,
    output logic       expired
);
    localparam int CW = $clog2(MAX_MS * CLKS_PER_MS + 1);

    logic [CW-1:0] count_q;
    logic [CW-1:0] load_val;

    assign load_val = CW'(ms) * CW'(CLKS_PER_MS) - CW'(1);
    assign expired  = (count_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= '0;
        else if (load)           count_q <= load_val;
        else if (count_q != '0)  count_q <= count_q - CW'(1);
    end

    // an elapsed timer stays elapsed until it is reloaded
    assert_timer_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);
endmodule

// File: rtl/disp_bringup_seq.sv
module disp_bringup_seq
    import dsq_pkg::*;
#(
    parameter int WIDTH       = 480,
    parameter int HEIGHT      = 272,
    parameter int CLKS_PER_MS = 50000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] fill_colour,
    output logic        item_valid,
    input  logic        item_ready,
    output logic [1:0]  item_kind,
    output logic [15:0] item_data,
    output logic        done
);
    localparam int NPIX  = WIDTH * HEIGHT;
    localparam int PIX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(NPIX - 1);

    typedef enum logic [2:0] {S_IDLE, S_CMD, S_PARAM, S_PIXEL, S_WAIT} state_e;

    state_e           state_q, state_d;
    logic [4:0]       cmd_q, cmd_d;
    logic [5:0]       par_q, par_d;
    logic [3:0]       left_q, left_d;
    logic [PIX_W-1:0] pix_q, pix_d;
    logic [15:0]      colour_q, colour_d;
    logic             done_q, done_d;
    logic             post, tmr_load, tmr_expired;
    cmd_entry_t       entry;
    logic [7:0]       par_byte;

    dsq_cmd_rom u_cmd_rom (.idx(cmd_q), .entry(entry));

    dsq_param_rom #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_param_rom (
        .idx(par_q), .value(par_byte));

    dsq_delay_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MAX_MS(MAX_MS)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .ms(entry.wait_ms),
        .expired(tmr_expired));

    // next-state and counter logic
    always_comb begin
        state_d  = state_q;
        cmd_d    = cmd_q;
        par_d    = par_q;
        left_d   = left_q;
        pix_d    = pix_q;
        colour_d = colour_q;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        post     = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                state_d  = S_CMD;
                cmd_d    = '0;
                par_d    = '0;
                colour_d = fill_colour;
            end
            S_CMD: if (item_ready) begin
                if (entry.n_params != 4'd0) begin
                    state_d = S_PARAM;
                    left_d  = entry.n_params;
                end else begin
                    post = 1'b1;
                end
            end
            S_PARAM: if (item_ready) begin
                par_d  = par_q + 6'd1;
                left_d = left_q - 4'd1;
                if (left_q == 4'd1) post = 1'b1;
            end
            S_PIXEL: if (item_ready) begin
                if (pix_q == PIX_LAST) begin
                    state_d = S_CMD;
                    cmd_d   = cmd_q + 5'd1;
                end else begin
                    pix_d = pix_q + PIX_W'(1);
                end
            end
            S_WAIT: if (tmr_expired) begin
                if (entry.last) begin
                    state_d = S_IDLE;
                    done_d  = 1'b1;
                end else begin
                    state_d = S_CMD;
                    cmd_d   = cmd_q + 5'd1;
                end
            end
            default: state_d = S_IDLE;
        endcase
        // after the last byte of a command: fill, pause, finish or move on
        if (post) begin
            if (entry.fill) begin
                state_d = S_PIXEL;
                pix_d   = '0;
            end else if (entry.wait_ms != 6'd0) begin
                state_d  = S_WAIT;
                tmr_load = 1'b1;
            end else if (entry.last) begin
                state_d = S_IDLE;
                done_d  = 1'b1;
            end else begin
                state_d = S_CMD;
                cmd_d   = cmd_q + 5'd1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            cmd_q    <= '0;
            par_q    <= '0;
            left_q   <= '0;
            pix_q    <= '0;
            colour_q <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            cmd_q    <= cmd_d;
            par_q    <= par_d;
            left_q   <= left_d;
            pix_q    <= pix_d;
            colour_q <= colour_d;
            done_q   <= done_d;
        end
    end

    // outputs
    always_comb begin
        item_valid = 1'b0;
        item_kind  = KIND_CMD;
        item_data  = '0;
        unique case (state_q)
            S_CMD: begin
                item_valid = 1'b1;
                item_data  = {8'h00, entry.opcode};
            end
            S_PARAM: begin
                item_valid = 1'b1;
                item_kind  = KIND_PARAM;
                item_data  = {8'h00, par_byte};
            end
            S_PIXEL: begin
                item_valid = 1'b1;
                item_kind  = KIND_PIXEL;
                item_data  = colour_q;
            end
            default: ;
        endcase
    end
    assign done = done_q;

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (item_valid && !item_ready) |=>
            (item_valid && $stable(item_kind) && $stable(item_data)));
    assert_first_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=>
            (item_valid && item_kind == KIND_CMD && item_data == 16'h00E2));
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (item_valid && item_kind != KIND_PIXEL) |-> (item_data[15:8] == 8'h00));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !item_valid);
    assert_pixel_const_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (item_valid && item_kind == KIND_PIXEL && $past(item_valid && item_kind == KIND_PIXEL))
            |-> $stable(item_data));
endmodule

// File: tb/disp_bringup_seq_tb_top.sv
module disp_bringup_seq_tb_top;
    localparam int W = 300;
    localparam int H = 2;
    localparam int C = 20;

    localparam logic [7:0] EXP_OP [18] = '{8'hE2, 8'hE0, 8'hE0, 8'h01, 8'hE6, 8'hB0,
        8'hB4, 8'hB6, 8'hBA, 8'hB8, 8'h36, 8'hBE, 8'hD0, 8'hF0, 8'h2A, 8'h2B, 8'h2C, 8'h29};
    localparam int EXP_N [18] = '{3, 1, 1, 0, 3, 7, 8, 7, 1, 2, 1, 6, 1, 1, 4, 4, 0, 0};
    localparam int EXP_W [18] = '{0, 1, 5, 5, 0, 0, 0, 0, 0, 0, 50, 0, 0, 0, 0, 0, 0, 5};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] fill_colour = 16'h0000;
    logic item_valid, item_ready, done;
    logic [1:0] item_kind;
    logic [15:0] item_data;

    always #10 clk = ~clk;

    disp_bringup_seq #(.WIDTH(W), .HEIGHT(H), .CLKS_PER_MS(C)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .fill_colour(fill_colour),
        .item_valid(item_valid), .item_ready(item_ready), .item_kind(item_kind),
        .item_data(item_data), .done(done));

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // ready driver
    int stall_mode = 0;
    int cyc = 0;
    initial begin
        item_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            item_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        end
    end

    // stream monitor
    logic [1:0]  it_kind [128];
    logic [15:0] it_data [128];
    int gap [128];
    int items_n, last_idx, lowrun, gap_end, pix_cnt, pix_bad, pix_misplaced;
    int done_cnt, post_valid;
    bit running, after_fill;
    logic [15:0] exp_colour;

    always @(negedge clk) begin
        if (done) begin
            gap_end = lowrun;
            done_cnt++;
            running = 1'b0;
        end else if (running && !item_valid) begin
            lowrun++;
        end
        if (!running && done_cnt > 0 && item_valid) post_valid++;
        if (item_valid) begin
            if (lowrun > 0 && last_idx >= 0 && last_idx < 128) gap[last_idx] = lowrun;
            lowrun = 0;
            if (item_ready) begin
                if (item_kind == 2'd2) begin
                    pix_cnt++;
                    if (item_data != exp_colour) pix_bad++;
                    if (!after_fill) pix_misplaced++;
                end else begin
                    if (items_n < 128) begin
                        it_kind[items_n] = item_kind;
                        it_data[items_n] = item_data;
                    end
                    last_idx   = items_n;
                    items_n++;
                    after_fill = (item_kind == 2'd0 && item_data == 16'h002C);
                end
            end
        end
    end

    task automatic clear_monitor();
        for (int i = 0; i < 128; i++) begin
            gap[i] = 0; it_kind[i] = 2'd3; it_data[i] = 16'hFFFF;
        end
        items_n = 0; last_idx = -1; lowrun = 0; gap_end = -1; pix_cnt = 0;
        pix_bad = 0; pix_misplaced = 0; done_cnt = 0; post_valid = 0;
        after_fill = 1'b0;
    endtask

    task automatic run_seq(input logic [15:0] colour, input int mode,
                           input bit poke, input bit change_colour);
        clear_monitor();
        exp_colour  = colour;
        fill_colour = colour;
        stall_mode  = mode;
        @(posedge clk); #2;
        start = 1'b1; running = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        if (change_colour) fill_colour = ~colour;
        for (int i = 0; i < 20000 && done_cnt == 0; i++) begin
            @(posedge clk);
            if (poke && i == 300) begin
                #2 start = 1'b1;
                @(posedge clk);
                #2 start = 1'b0;
            end
        end
        chk(done_cnt > 0, "R9", "sequence finished before timeout", done_cnt, 1);
        repeat (40) @(posedge clk);
    endtask

    // walks the recorded stream against the expected sequence
    task automatic check_stream(input string tag);
        int pos = 0;
        int bad_order = 0;
        int bad_upper = 0;
        int bad_gap = 0;
        int pidx = 0;
        logic [7:0] pv [50];
        logic [15:0] col_end = 16'(W - 1);
        logic [15:0] row_end = 16'(H - 1);
        for (int k = 0; k < 18; k++) begin
            if (it_kind[pos] != 2'd0 || it_data[pos][7:0] != EXP_OP[k]) bad_order++;
            if (it_data[pos][15:8] != 8'h00) bad_upper++;
            pos++;
            for (int j = 0; j < EXP_N[k]; j++) begin
                if (it_kind[pos] != 2'd1) bad_order++;
                if (it_data[pos][15:8] != 8'h00) bad_upper++;
                if (pidx < 50) pv[pidx] = it_data[pos][7:0];
                pidx++;
                pos++;
            end
            if (k < 17) begin
                if (EXP_W[k] != 0)
                    chk(gap[pos-1] == EXP_W[k] * C, "R4",
                        $sformatf("%s pause after opcode %0h", tag, EXP_OP[k]),
                        gap[pos-1], EXP_W[k] * C);
                else if (gap[pos-1] != 0) bad_gap++;
            end
        end
        chk(items_n == 68 && bad_order == 0, "R2", {tag, " opcode order and counts"},
            bad_order + items_n, 68);
        chk(bad_upper == 0, "R2", {tag, " upper byte zero"}, bad_upper, 0);
        chk(bad_gap == 0, "R11", {tag, " no idle between items"}, bad_gap, 0);
        chk(pv[3] == 8'h01 && pv[4] == 8'h03, "R3", {tag, " clock-start params"},
            {pv[3], pv[4]}, 16'h0103);
        chk(pv[41] == 8'h03, "R3", {tag, " pixel format param"}, pv[41], 8'h03);
        chk({pv[42], pv[43], pv[44], pv[45]} == {16'h0000, col_end}, "R5",
            {tag, " column window"}, {pv[42], pv[43], pv[44], pv[45]}, {16'h0000, col_end});
        chk({pv[46], pv[47], pv[48], pv[49]} == {16'h0000, row_end}, "R5",
            {tag, " page window"}, {pv[46], pv[47], pv[48], pv[49]}, {16'h0000, row_end});
        chk({pv[10], pv[11], pv[12], pv[13]} == {col_end, row_end}, "R5",
            {tag, " resolution fields"}, {pv[10], pv[11], pv[12], pv[13]}, {col_end, row_end});
        chk(pix_cnt == W * H && pix_misplaced == 0, "R6", {tag, " pixel count"},
            pix_cnt, W * H);
        chk(pix_bad == 0, "R6", {tag, " pixel colour"}, pix_bad, 0);
        chk(gap_end == 5 * C, "R9", {tag, " final pause before done"}, gap_end, 5 * C);
        chk(done_cnt == 1 && post_valid == 0, "R9", {tag, " single done, quiet after"},
            done_cnt * 100 + post_valid, 100);
    endtask

    task automatic test_reset();
        int seen = 0;
        rst_n = 1'b0;
        running = 1'b0;
        clear_monitor();
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(item_valid == 1'b0 && done == 1'b0, "R1", "outputs low after reset",
            {item_valid, done}, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (item_valid || done) seen++;
        end
        chk(seen == 0, "R1", "no activity without start", seen, 0);
    endtask

    task automatic test_plain();
        run_seq(16'hF81F, 0, 1'b0, 1'b0);
        check_stream("plain");
    endtask

    task automatic test_backpressure();
        run_seq(16'h07E0, 1, 1'b0, 1'b0);
        check_stream("stalled");
        chk(items_n == 68 && pix_cnt == W * H, "R7", "stalls keep the sequence intact",
            items_n, 68);
    endtask

    task automatic test_latch_and_restart();
        run_seq(16'h1234, 0, 1'b1, 1'b1);
        check_stream("poked");
        chk(pix_bad == 0, "R8", "colour changed after start ignored", pix_bad, 0);
        chk(done_cnt == 1 && items_n == 68, "R10", "start while busy ignored",
            done_cnt * 1000 + items_n, 1068);
    endtask

    initial begin
        #(200000 * 20);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset();
        test_plain();
        test_backpressure();
        test_latch_and_restart();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule